// File: doc/BRIEF.md
# Ordering Table Clear DMA

This engine fills a region of memory with an empty, reverse-linked ordering table. Software writes a start address, an entry count and a control word. If the control word is the one recognised start command, the engine walks downward from the word-aligned start address and issues one memory write per entry. Each entry holds the address of the word just below it. The lowest entry written holds an end-of-list marker instead.

Writes leave the block through a simple write port: a write strobe, an address, data and a ready input. Any other control word finishes at once, with no memory traffic. A job with no entries to write also finishes at once. When a job ends, the engine clears the run and trigger bits of its control register and pulses its channel interrupt for one cycle.

Top module: `ot_clear_dma`

## Requirements
- R1: A job that writes memory starts only when the control word written is exactly 0x11000002. Any other control word writes nothing and completes with an interrupt pulse in the cycle after the control write.
- R2: The start address is made word-aligned by forcing bits 1:0 of `baseAddr` to zero.
- R3: A job makes exactly W = min(`entryCount`, alignedBase/4) writes, at the addresses alignedBase, alignedBase-4, alignedBase-8 and so on downward. A count of zero gives W = 0.
- R4: Every entry except the lowest one written at byte address A holds (A-4) masked to 24 bits, zero-extended to 32 bits.
- R5: The lowest entry of a job holds 0x00FFFFFF. A count of 1 therefore writes a single entry holding only this value.
- R6: No write goes to byte address 0. The walk stops after the entry at address 4, even if entries remain.
- R7: One write is accepted on each cycle in which `memReady` is high. While `memReady` is low, `memWe`, `memAddr` and `memData` hold steady. With `memReady` always high, the interrupt appears W+1 cycles after the start edge.
- R8: `irq` is a single-cycle pulse. It is raised in the cycle after the last write is accepted, or in the cycle after the control write when no write is made.
- R9: On completion, bits 24 and 28 of `ctrlOut` are cleared. All other bits keep the value that was written.
- R10: Control writes that arrive while the engine is busy (from the start edge until the interrupt cycle has ended) are ignored.
- R11: After reset, `busy`, `memWe` and `irq` are low and `ctrlOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlData | input | 32 | Control word to write |
| baseAddr | input | AW | Start byte address, sampled on a control write |
| entryCount | input | CW | Number of entries, sampled on a control write |
| ctrlOut | output | 32 | Current control register value |
| busy | output | 1 | Engine is running a job or finishing it |
| memWe | output | 1 | Memory write request |
| memAddr | output | AW | Byte address of the write |
| memData | output | 32 | Entry value being written |
| memReady | input | 1 | Memory accepts the write this cycle |
| irq | output | 1 | Channel completion pulse |

## Verification
The assertions check several rules on every cycle:
- writes appear only while the engine is busy;
- write addresses are word-aligned and never zero;
- successive accepted writes step down by exactly four;
- a stalled write holds steady;
- the interrupt lasts one cycle, and the run and trigger bits are cleared right after it.

Other properties depend on the contents of a whole job, so only the bench scenarios can show them:
- the exact number of writes;
- the link value stored in each entry;
- where the terminator lands when the count runs out or the bottom of memory is reached;
- the latency with full throughput;
- that non-start commands and control writes made while busy are rejected.

// File: rtl/otc_pkg.sv
package otc_pkg;
  localparam logic [31:0] START_CODE = 32'h1100_0002;
  localparam int RUN_BIT = 24;
  localparam int TRIG_BIT = 28;
  localparam int LINK_W = 24;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } otcState_e;
endpackage

// File: rtl/otc_ctrl.sv
module otc_ctrl
  import otc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctrlWe,
  input  logic         isStart,
  input  logic         isEmpty,
  input  logic         lastEntry,
  input  logic         memReady,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         memWe,
  output logic         irq
);
  otcState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (ctrlWe) begin
          strb.load = 1'b1;
          nextState = (isStart && !isEmpty) ? ST_RUN : ST_DONE;
        end
      end
      ST_RUN: begin
        if (memReady) begin
          strb.step = 1'b1;
          if (lastEntry) nextState = ST_DONE;
        end
      end
      ST_DONE: begin
        strb.finish = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign memWe = (state == ST_RUN);
  assign irq   = (state == ST_DONE);
endmodule

// File: rtl/otc_datapath.sv
module otc_datapath
  import otc_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strb,
  input  logic [31:0]   ctrlData,
  input  logic [AW-1:0] baseAddr,
  input  logic [CW-1:0] entryCount,
  output logic          isStart,
  output logic          isEmpty,
  output logic          lastEntry,
  output logic [31:0]   ctrlOut,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memData
);
  localparam logic [31:0] LINK_MASK = (32'h1 << LINK_W) - 32'h1;
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  logic [31:0]   ctrlReg;
  logic [AW-1:0] curAddr;
  logic [CW-1:0] remaining;
  logic [AW-1:0] belowAddr;

  assign isStart   = (ctrlData == START_CODE);
  assign isEmpty   = (entryCount == '0) || (baseAddr[AW-1:2] == '0);
  assign lastEntry = (remaining == CW'(1)) || (curAddr[AW-1:2] == (AW-2)'(1));
  assign belowAddr = curAddr - WORD_STEP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      curAddr   <= '0;
      remaining <= '0;
    end else begin
      if (strb.load) begin
        ctrlReg   <= ctrlData;
        curAddr   <= {baseAddr[AW-1:2], 2'b00};
        remaining <= entryCount;
      end else if (strb.step) begin
        curAddr   <= belowAddr;
        remaining <= remaining - CW'(1);
      end
      if (strb.finish) begin
        ctrlReg[RUN_BIT]  <= 1'b0;
        ctrlReg[TRIG_BIT] <= 1'b0;
      end
    end
  end

  assign ctrlOut = ctrlReg;
  assign memAddr = curAddr;
  assign memData = lastEntry ? LINK_MASK : (32'(belowAddr) & LINK_MASK);
endmodule

// File: rtl/ot_clear_dma.sv
module ot_clear_dma
  import otc_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWe,
  input  logic [31:0]   ctrlData,
  input  logic [AW-1:0] baseAddr,
  input  logic [CW-1:0] entryCount,
  output logic [31:0]   ctrlOut,
  output logic          busy,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memData,
  input  logic          memReady,
  output logic          irq
);
  ctrlStrobes_t strb;
  logic isStart, isEmpty, lastEntry;

  otc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .isStart(isStart),
    .isEmpty(isEmpty), .lastEntry(lastEntry), .memReady(memReady),
    .strb(strb), .busy(busy), .memWe(memWe), .irq(irq)
  );

  otc_datapath #(.AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlData(ctrlData),
    .baseAddr(baseAddr), .entryCount(entryCount), .isStart(isStart),
    .isEmpty(isEmpty), .lastEntry(lastEntry), .ctrlOut(ctrlOut),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/otc_chk.sv
module otc_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [31:0]   memData,
  input logic          memReady,
  input logic          irq,
  input logic [31:0]   ctrlOut
);
  // R3
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R2
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[1:0] == 2'b00));

  // R6
  no_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr != '0));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memReady) |=> (!memWe || (memAddr == $past(memAddr) - AW'(4))));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !memReady) |=> (memWe && $stable(memAddr) && $stable(memData)));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R8
  irq_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !memWe);

  // R9
  bits_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> (!ctrlOut[24] && !ctrlOut[28]));
endmodule

bind ot_clear_dma otc_chk #(.AW(AW)) u_otc_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memWe(memWe), .memAddr(memAddr),
  .memData(memData), .memReady(memReady), .irq(irq), .ctrlOut(ctrlOut)
);

// File: tb/tb_ot_clear_dma.sv
module tb_ot_clear_dma;
  localparam int AW = 24;
  localparam int CW = 16;
  localparam int MEMW = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [31:0] ctrlData = '0;
  logic [AW-1:0] baseAddr = '0;
  logic [CW-1:0] entryCount = '0;
  logic [31:0] ctrlOut;
  logic busy, memWe, irq;
  logic [AW-1:0] memAddr;
  logic [31:0] memData;
  logic memReady = 1'b1;

  int checks = 0;
  int fails = 0;
  int writes = 0;
  int badWrites = 0;
  int readyMode = 0;
  logic [31:0] mem [MEMW];

  always #5 clk = ~clk;

  ot_clear_dma #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .baseAddr(baseAddr), .entryCount(entryCount), .ctrlOut(ctrlOut),
    .busy(busy), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .memReady(memReady), .irq(irq)
  );

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'h5A;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (readyMode)
        0: memReady = 1'b1;
        1: memReady = ~memReady;
        default: memReady = lfsr[0];
      endcase
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (memWe && memReady) begin
        writes++;
        if (memAddr == '0 || memAddr >= AW'(MEMW * 4)) badWrites++;
        else mem[memAddr[9:2]] = memData;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runJob(input logic [31:0] code, input int base, input int cnt,
                        input int mode, input bit intrude);
    int aligned, w, n, memBad;
    bit seen;
    logic [31:0] expv;
    for (int i = 0; i < MEMW; i++) mem[i] = 32'hDEAD_BEEF;
    readyMode = mode;
    @(negedge clk);
    writes = 0;
    badWrites = 0;
    ctrlWe = 1'b1; ctrlData = code; baseAddr = AW'(base); entryCount = CW'(cnt);
    aligned = base & ~3;
    w = (code == 32'h1100_0002) ? ((cnt < aligned / 4) ? cnt : aligned / 4) : 0;
    n = 0; seen = 1'b0;
    while (!seen && n < 3000) begin
      @(negedge clk);
      n++;
      ctrlWe = 1'b0;
      seen = irq;
      if (!seen && intrude && n == 2) begin
        ctrlWe = 1'b1; ctrlData = 32'h1100_0003; baseAddr = 24'h300; entryCount = 5;
      end
    end
    ctrlWe = 1'b0;
    check(seen, "R8", "irq arrived", n, w + 1);
    if (mode == 0) check(n == w + 1, "R7", "cycles to irq", n, w + 1);
    check(writes == w, "R3", "write count", writes, w);
    check(badWrites == 0, "R6", "writes at address 0 or out of range", badWrites, 0);
    memBad = 0;
    for (int i = 0; i < MEMW; i++) begin
      int a, k;
      a = i * 4;
      k = (aligned - a) / 4;
      if (a <= aligned && k < w) expv = (k == w - 1) ? 32'h00FF_FFFF : 32'((a - 4) & 32'hFF_FFFF);
      else expv = 32'hDEAD_BEEF;
      if (mem[i] != expv) begin
        memBad++;
        check(1'b0, (k == w - 1) ? "R5" : "R4", "entry value", mem[i], expv);
      end
    end
    check(memBad == 0, "R4", "table image mismatches", memBad, 0);
    @(negedge clk);
    check(!irq, "R8", "irq single cycle", irq, 0);
    check(!busy, "R10", "idle after job", busy, 0);
    check(ctrlOut == (code & ~32'h1100_0000), "R9", "ctrl after completion",
          ctrlOut, code & ~32'h1100_0000);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !memWe && !irq, "R11", "reset outputs", {busy, memWe, irq}, 0);
    check(ctrlOut == 0, "R11", "reset ctrl", ctrlOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R3 R4 R5 R7: sweep counts, alignments (R2) and ready patterns
    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 10; c++) begin
        runJob(32'h1100_0002, 'h40, c, m, 1'b0);
        runJob(32'h1100_0002, 'h43, c, m, 1'b0);
        runJob(32'h1100_0002, 'h3FE, c, m, 1'b0);
      end
    // R6: bottom of memory reached before the count runs out
    runJob(32'h1100_0002, 'h10, 10, 0, 1'b0);
    runJob(32'h1100_0002, 'h4, 3, 2, 1'b0);
    runJob(32'h1100_0002, 'h0, 5, 0, 1'b0);
    runJob(32'h1100_0002, 'h2, 4, 1, 1'b0);
    // R5: a single entry holds only the terminator
    runJob(32'h1100_0002, 'h200, 1, 0, 1'b0);
    // R1: control words other than the start command
    runJob(32'h1100_0003, 'h80, 5, 0, 1'b0);
    runJob(32'h0100_0002, 'h80, 5, 0, 1'b0);
    runJob(32'h1000_0002, 'h80, 5, 0, 1'b0);
    runJob(32'h0000_0000, 'h80, 5, 0, 1'b0);
    // R10: control write during a running job is ignored
    runJob(32'h1100_0002, 'h200, 8, 0, 1'b1);
    runJob(32'h1100_0002, 'h100, 12, 1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule